// File: doc/BRIEF.md
# DMA minor loop sequencer

This block is the engine core of one DMA channel. It executes a single minor loop of a transfer descriptor. A start pulse captures the descriptor: source address, destination address, signed per-access offsets for each side, a byte-count word and the current major iteration count. The engine then moves 32-bit words through read/write pairs on a simple request/grant memory port until the minor byte count is spent. Once the loop is under way it cannot be abandoned. A stall input can pause it between pairs, and it then carries on from the same position.

When the loop ends, the engine can add a signed end-of-loop offset to the source address, the destination address or both. It then presents the final addresses and the decremented major count on a one-cycle write-back strobe. If that count has reached zero, a major-done pulse is raised in the same cycle.

The byte-count word has three layouts, selected by the `map_en` input and the two top bits of the word. The state machine has these states: SQ_IDLE (waiting for start), SQ_LOAD (decoding the byte-count word), SQ_HOLD (paused by stall), SQ_READ (source read in flight), SQ_WRITE (destination write in flight), SQ_STEP (per-access address advance and count decrement), SQ_FOLD (end-of-loop offset) and SQ_RETIRE (write-back). Its transitions are:
- SQ_IDLE→SQ_LOAD on start.
- SQ_LOAD→SQ_FOLD when the byte count is zero. Otherwise SQ_LOAD→SQ_HOLD while stall is high, and SQ_LOAD→SQ_READ when it is not.
- SQ_HOLD→SQ_READ when stall drops.
- SQ_READ→SQ_WRITE on grant.
- SQ_WRITE→SQ_STEP on grant.
- SQ_STEP→SQ_FOLD when no more than 4 bytes remained. Otherwise SQ_STEP→SQ_HOLD while stall is high, and SQ_STEP→SQ_READ when it is not.
- SQ_FOLD→SQ_RETIRE always.
- SQ_RETIRE→SQ_IDLE always.

Top module: `dmaseq_core`

## Requirements
- R1: A start pulse in the idle state captures all descriptor inputs and raises busy until the write-back cycle. A start pulse while busy is ignored, and changing the descriptor inputs mid-loop has no effect.
- R2: With `map_en` low, the whole 32-bit byte-count word is the minor byte count.
- R3: With `map_en` high and word bits 31 and 30 both clear, the byte count is bits 29..0 and no end-of-loop offset is applied.
- R4: With `map_en` high and word bit 31 or bit 30 set, bit 31 enables the offset on the source side and bit 30 on the destination side. Bits 29..10 are a signed offset that is sign-extended to 32 bits, and bits 9..0 are the byte count.
- R5: Each pair reads the word at the current source address and writes that same data to the current destination address. A byte count of n gives ceil(n/4) pairs.
- R6: After every pair, the source and destination addresses each advance by their own 16-bit per-access offset, sign-extended.
- R7: The end-of-loop offset is added after the last per-access advance, and only to the enabled sides.
- R8: A memory request keeps its address, direction and write data unchanged until it is granted.
- R9: While stall is high, no new pair starts. An access already requested completes along with its partner write, and after stall drops the loop resumes at the next pair with correct data.
- R10: Write-back is a one-cycle `wb_valid` carrying the final addresses and the major count minus one. The engine is idle in the following cycle.
- R11: `major_done` pulses in the write-back cycle exactly when the decremented major count is zero.
- R12: A zero byte count performs no memory access but still writes back, with the end-of-loop offset applied.
- R13: A stall raised after the final pair's write grant does not delay write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Channel activation pulse |
| map_en | input | 1 | Global loop-mapping enable (selects byte-count word layout) |
| desc_saddr | input | 32 | Descriptor source address |
| desc_daddr | input | 32 | Descriptor destination address |
| desc_soff | input | 16 | Signed per-access source offset |
| desc_doff | input | 16 | Signed per-access destination offset |
| desc_nbytes | input | 32 | Byte-count word |
| desc_citer | input | 15 | Current major iteration count |
| stall | input | 1 | Pause request (bandwidth throttle or preemption) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access grant; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Minor loop in progress |
| wb_valid | output | 1 | Write-back strobe |
| wb_saddr | output | 32 | Written-back source address |
| wb_daddr | output | 32 | Written-back destination address |
| wb_citer | output | 15 | Written-back major count |
| major_done | output | 1 | Major loop complete pulse |

## Verification
Two events can land in the same cycle. A stall can arrive in the very cycle the last write of the loop is granted, and the write-back strobe can coincide with the major-done pulse. The first case is provoked by raising stall on the falling edge right after the final write grant and holding it. It is judged correct if write-back still appears within three cycles while stall is high, with the right addresses. The second case is judged by running descriptors whose major count is one and descriptors whose count is larger, and checking that `major_done` accompanies `wb_valid` only in the first kind.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_HOLD,
        SQ_READ,
        SQ_WRITE,
        SQ_STEP,
        SQ_FOLD,
        SQ_RETIRE
    } sq_state_e;

    localparam int unsigned BEAT_BYTES = 4;
    localparam int unsigned SIDE_SRC   = 0;
    localparam int unsigned SIDE_DST   = 1;
    localparam int unsigned SIDES      = 2;

endpackage

// File: rtl/dmaseq_count_decode.sv
module dmaseq_count_decode #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned FOLD_W   = 20,
    parameter int unsigned FOLD_LSB = 10
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              map_en_i,
    output logic [WORD_W-1:0] bytes_o,
    output logic              src_fold_o,
    output logic              dst_fold_o,
    output logic [WORD_W-1:0] fold_off_o
);
    localparam int unsigned SRC_BIT  = WORD_W - 1;
    localparam int unsigned DST_BIT  = WORD_W - 2;
    localparam int unsigned FOLD_MSB = FOLD_LSB + FOLD_W - 1;
    localparam int unsigned EXT_W    = WORD_W - FOLD_W;
    localparam int unsigned CNT_PAD  = WORD_W - FOLD_LSB;

    logic offset_fmt;

    assign offset_fmt = map_en_i && (word_i[SRC_BIT] || word_i[DST_BIT]);

    always_comb begin
        bytes_o    = word_i;
        src_fold_o = 1'b0;
        dst_fold_o = 1'b0;
        fold_off_o = '0;
        if (offset_fmt) begin
            src_fold_o = word_i[SRC_BIT];
            dst_fold_o = word_i[DST_BIT];
            fold_off_o = {{EXT_W{word_i[FOLD_MSB]}}, word_i[FOLD_MSB:FOLD_LSB]};
            bytes_o    = {{CNT_PAD{1'b0}}, word_i[FOLD_LSB-1:0]};
        end else if (map_en_i) begin
            bytes_o    = {2'b00, word_i[DST_BIT-1:0]};
        end
    end

endmodule

// File: rtl/dmaseq_addr_lane.sv
module dmaseq_addr_lane #(
    parameter int unsigned AW     = 32,
    parameter int unsigned STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [AW-1:0]     load_addr_i,
    input  logic              step_i,
    input  logic [STEP_W-1:0] step_off_i,
    input  logic              fold_i,
    input  logic              fold_en_i,
    input  logic [AW-1:0]     fold_off_i,
    output logic [AW-1:0]     addr_o
);
    localparam int unsigned EXT_W = AW - STEP_W;

    logic [AW-1:0] addr_q;
    logic [AW-1:0] step_ext;

    assign step_ext = {{EXT_W{step_off_i[STEP_W-1]}}, step_off_i};
    assign addr_o   = addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= load_addr_i;
        end else if (step_i) begin
            addr_q <= addr_q + step_ext;
        end else if (fold_i && fold_en_i) begin
            addr_q <= addr_q + fold_off_i;
        end
    end

    AST_LANE_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_i, step_i, fold_i})); // R6

    AST_LANE_FOLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (fold_i && !fold_en_i) |=> $stable(addr_o)); // R7

endmodule

// File: rtl/dmaseq_core.sv
module dmaseq_core
    import dmaseq_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned OFFW = 16,
    parameter int unsigned CW   = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            map_en,
    input  logic [AW-1:0]   desc_saddr,
    input  logic [AW-1:0]   desc_daddr,
    input  logic [OFFW-1:0] desc_soff,
    input  logic [OFFW-1:0] desc_doff,
    input  logic [AW-1:0]   desc_nbytes,
    input  logic [CW-1:0]   desc_citer,
    input  logic            stall,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_gnt,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            wb_valid,
    output logic [AW-1:0]   wb_saddr,
    output logic [AW-1:0]   wb_daddr,
    output logic [CW-1:0]   wb_citer,
    output logic            major_done
);
    localparam logic [AW-1:0] BEAT = AW'(BEAT_BYTES);

    sq_state_e state_q, state_d;

    logic [AW-1:0]   word_q;
    logic [AW-1:0]   cnt_q;
    logic [CW-1:0]   citer_q;
    logic [DW-1:0]   data_q;
    logic            fold_src_q, fold_dst_q;
    logic [AW-1:0]   fold_off_q;

    logic [AW-1:0]   dec_bytes;
    logic            dec_src, dec_dst;
    logic [AW-1:0]   dec_off;

    logic            lane_load, lane_step, lane_fold;
    logic            last_pair;
    logic [CW-1:0]   citer_left;

    logic [AW-1:0]   lane_init  [SIDES];
    logic [OFFW-1:0] lane_delta [SIDES];
    logic            lane_fen   [SIDES];
    logic [AW-1:0]   lane_addr  [SIDES];

    dmaseq_count_decode #(
        .WORD_W   (AW),
        .FOLD_W   (20),
        .FOLD_LSB (10)
    ) u_decode (
        .word_i     (word_q),
        .map_en_i   (map_en),
        .bytes_o    (dec_bytes),
        .src_fold_o (dec_src),
        .dst_fold_o (dec_dst),
        .fold_off_o (dec_off)
    );

    assign lane_init[SIDE_SRC]  = desc_saddr;
    assign lane_init[SIDE_DST]  = desc_daddr;
    assign lane_fen[SIDE_SRC]   = fold_src_q;
    assign lane_fen[SIDE_DST]   = fold_dst_q;

    for (genvar g = 0; g < SIDES; g++) begin : g_lane
        dmaseq_addr_lane #(
            .AW     (AW),
            .STEP_W (OFFW)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (lane_load),
            .load_addr_i (lane_init[g]),
            .step_i      (lane_step),
            .step_off_i  (lane_delta[g]),
            .fold_i      (lane_fold),
            .fold_en_i   (lane_fen[g]),
            .fold_off_i  (fold_off_q),
            .addr_o      (lane_addr[g])
        );
    end

    assign last_pair  = (cnt_q <= BEAT);
    assign citer_left = citer_q - CW'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (start) state_d = SQ_LOAD;
            SQ_LOAD: begin
                if (dec_bytes == '0)  state_d = SQ_FOLD;
                else if (stall)       state_d = SQ_HOLD;
                else                  state_d = SQ_READ;
            end
            SQ_HOLD:   if (!stall)  state_d = SQ_READ;
            SQ_READ:   if (mem_gnt) state_d = SQ_WRITE;
            SQ_WRITE:  if (mem_gnt) state_d = SQ_STEP;
            SQ_STEP: begin
                if (last_pair)        state_d = SQ_FOLD;
                else if (stall)       state_d = SQ_HOLD;
                else                  state_d = SQ_READ;
            end
            SQ_FOLD:   state_d = SQ_RETIRE;
            SQ_RETIRE: state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    // Outputs and strobes
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        wb_valid   = 1'b0;
        major_done = 1'b0;
        busy       = (state_q != SQ_IDLE);
        lane_load  = 1'b0;
        lane_step  = 1'b0;
        lane_fold  = 1'b0;
        unique case (state_q)
            SQ_IDLE:   lane_load = start;
            SQ_READ: begin
                mem_req  = 1'b1;
                mem_addr = lane_addr[SIDE_SRC];
            end
            SQ_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = lane_addr[SIDE_DST];
                mem_wdata = data_q;
            end
            SQ_STEP:   lane_step = 1'b1;
            SQ_FOLD:   lane_fold = 1'b1;
            SQ_RETIRE: begin
                wb_valid   = 1'b1;
                major_done = (citer_left == '0);
            end
            default: ;
        endcase
    end

    assign wb_saddr = lane_addr[SIDE_SRC];
    assign wb_daddr = lane_addr[SIDE_DST];
    assign wb_citer = citer_left;

    // Descriptor capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q                <= '0;
            citer_q               <= '0;
            lane_delta[SIDE_SRC]  <= '0;
            lane_delta[SIDE_DST]  <= '0;
        end else if (state_q == SQ_IDLE && start) begin
            word_q                <= desc_nbytes;
            citer_q               <= desc_citer;
            lane_delta[SIDE_SRC]  <= desc_soff;
            lane_delta[SIDE_DST]  <= desc_doff;
        end
    end

    // Byte counter and end-of-loop offset selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            fold_src_q <= 1'b0;
            fold_dst_q <= 1'b0;
            fold_off_q <= '0;
        end else if (state_q == SQ_LOAD) begin
            cnt_q      <= dec_bytes;
            fold_src_q <= dec_src;
            fold_dst_q <= dec_dst;
            fold_off_q <= dec_off;
        end else if (state_q == SQ_STEP) begin
            cnt_q      <= last_pair ? '0 : (cnt_q - BEAT);
        end
    end

    // Read data buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state_q == SQ_READ && mem_gnt) begin
            data_q <= mem_rdata;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R8

    AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !mem_req) |=> !mem_req); // R9

    AST_CNT_NONRISING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {SQ_HOLD, SQ_READ, SQ_WRITE, SQ_STEP, SQ_FOLD}) |=> (cnt_q <= $past(cnt_q))); // R5

    AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (!wb_valid && !busy)); // R10

    AST_DONE_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
        major_done |-> wb_valid); // R11

    AST_WB_AFTER_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_FOLD) |=> wb_valid); // R13

endmodule

// File: tb/dmaseq_core_test.sv
module dmaseq_core_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        map_en = 1'b0;
    logic [31:0] desc_saddr = '0, desc_daddr = '0, desc_nbytes = '0;
    logic [15:0] desc_soff = '0, desc_doff = '0;
    logic [14:0] desc_citer = '0;
    logic        stall = 1'b0;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, wb_valid, major_done;
    logic [31:0] wb_saddr, wb_daddr;
    logic [14:0] wb_citer;

    logic [31:0] mem [0:255];
    int total = 0, bad = 0;
    int rd_count = 0, wr_count = 0, hold_err = 0, gnt_lat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmaseq_core uut (
        .clk(clk), .rst_n(rst_n), .start(start), .map_en(map_en),
        .desc_saddr(desc_saddr), .desc_daddr(desc_daddr),
        .desc_soff(desc_soff), .desc_doff(desc_doff),
        .desc_nbytes(desc_nbytes), .desc_citer(desc_citer), .stall(stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .busy(busy), .wb_valid(wb_valid), .wb_saddr(wb_saddr),
        .wb_daddr(wb_daddr), .wb_citer(wb_citer), .major_done(major_done)
    );

    function automatic logic [31:0] pat(input int i);
        return 32'hA500_0000 + i * 32'h0001_0203;
    endfunction

    // Behavioural memory: grants after gnt_lat waiting cycles, checks request holding
    initial begin
        int          wait_cnt;
        logic        pend;
        logic [31:0] pa;
        logic        pw;
        wait_cnt = 0; pend = 1'b0; pa = '0; pw = 1'b0;
        mem_gnt = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (pend && (!mem_req || mem_addr != pa || mem_we != pw)) hold_err++;
            mem_gnt = 1'b0;
            pend = 1'b0;
            if (mem_req && rst_n) begin
                if (wait_cnt < gnt_lat) begin
                    wait_cnt++;
                    pend = 1'b1; pa = mem_addr; pw = mem_we;
                end else begin
                    wait_cnt = 0;
                    mem_gnt = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr[9:2]] = mem_wdata;
                        wr_count++;
                    end else begin
                        mem_rdata = mem[mem_addr[9:2]];
                        rd_count++;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // mode: 0 none, 1 stall between pairs, 2 stall during a read,
    //       3 stall at final write grant, 4 restart attempt while busy
    task automatic run_xfer(input string req, input logic [31:0] s, input logic [31:0] d,
                            input logic [15:0] so, input logic [15:0] dof,
                            input logic [31:0] nb, input logic me, input logic [14:0] ci,
                            input int lat, input int mode);
        logic [31:0] cnt, moff, es, ed;
        logic        sen, den, found, did;
        int          pairs, rd0, wr0, miss, cyc, stall_cyc, r_snap, w_snap;
        sen = 1'b0; den = 1'b0; moff = '0;
        if (!me) cnt = nb;
        else if (nb[31] || nb[30]) begin
            sen = nb[31]; den = nb[30];
            moff = {{12{nb[29]}}, nb[29:10]};
            cnt = {22'd0, nb[9:0]};
        end else cnt = {2'b00, nb[29:0]};
        pairs = int'((cnt + 32'd3) / 32'd4);
        es = s + 32'(pairs) * {{16{so[15]}}, so} + (sen ? moff : 32'd0);
        ed = d + 32'(pairs) * {{16{dof[15]}}, dof} + (den ? moff : 32'd0);

        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        gnt_lat = lat;
        desc_saddr = s; desc_daddr = d; desc_soff = so; desc_doff = dof;
        desc_nbytes = nb; map_en = me; desc_citer = ci;
        rd0 = rd_count; wr0 = wr_count;
        found = 1'b0; did = 1'b0; cyc = 0; stall_cyc = 0;

        @(negedge clk); #1;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        while (!found && cyc < 1000) begin
            if (wb_valid) begin
                found = 1'b1;
            end else begin
                if (mode == 1 && !did && wr_count - wr0 == 2) begin
                    did = 1'b1; stall = 1'b1;
                    r_snap = rd_count; w_snap = wr_count;
                    repeat (8) @(negedge clk);
                    #1;
                    chk(rd_count == r_snap && wr_count == w_snap, "R9", "no access while stalled",
                        32'(rd_count + wr_count), 32'(r_snap + w_snap));
                    chk(busy == 1'b1, "R9", "busy while paused", 32'(busy), 32'd1);
                    stall = 1'b0;
                end
                if (mode == 2 && !did && mem_req && !mem_we && !mem_gnt && rd_count - rd0 == 1) begin
                    did = 1'b1; stall = 1'b1;
                    repeat (8) @(negedge clk);
                    #1;
                    chk(rd_count - rd0 == 2 && wr_count - wr0 == 2, "R9", "in-flight pair finishes, next held",
                        32'(rd_count - rd0 + wr_count - wr0), 32'd4);
                    stall = 1'b0;
                end
                if (mode == 3 && !did && wr_count - wr0 == pairs) begin
                    did = 1'b1; stall = 1'b1;
                end
                if (mode == 3 && did) stall_cyc++;
                if (mode == 4 && cyc == 3) begin
                    desc_saddr = 32'h0000_0300; desc_daddr = 32'h0000_0000;
                    desc_nbytes = 32'd64; desc_citer = 15'd1;
                    start = 1'b1;
                end
                if (mode == 4 && cyc == 4) start = 1'b0;
                @(negedge clk); #1;
                cyc++;
            end
        end

        chk(found, req, "write-back seen", 32'(found), 32'd1);
        if (mode == 3) begin
            chk(stall == 1'b1 && stall_cyc <= 3, "R13", "write-back despite stall",
                32'(stall_cyc), 32'd3);
            stall = 1'b0;
        end
        chk(wb_saddr == es, {req, " R6/R7"}, "source write-back", wb_saddr, es);
        chk(wb_daddr == ed, {req, " R6/R7"}, "destination write-back", wb_daddr, ed);
        chk(wb_citer == ci - 15'd1, "R10", "major count write-back", 32'(wb_citer), 32'(ci - 15'd1));
        chk(major_done == (ci == 15'd1), "R11", "major done pulse", 32'(major_done), 32'(ci == 15'd1));
        chk(rd_count - rd0 == pairs && wr_count - wr0 == pairs, {req, " R5"}, "pair count",
            32'(rd_count - rd0), 32'(pairs));
        miss = 0;
        for (int k = 0; k < pairs; k++) begin
            logic [31:0] sa, da;
            sa = s + 32'(k) * {{16{so[15]}}, so};
            da = d + 32'(k) * {{16{dof[15]}}, dof};
            if (mem[da[9:2]] !== pat(int'(sa[9:2]))) miss++;
        end
        chk(miss == 0, {req, " R5"}, "copied data mismatches", 32'(miss), 32'd0);
        @(negedge clk); #1;
        chk(!wb_valid && !busy, "R10", "idle after single write-back", 32'({wb_valid, busy}), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !mem_req && !wb_valid && !major_done, "R1", "reset outputs",
            32'({busy, mem_req, wb_valid, major_done}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: mapping off, full word is the count
        run_xfer("R2", 32'h100, 32'h200, 16'd4, 16'd4, 32'd16, 1'b0, 15'd3, 0, 0);
        // R3: mapping on, no offsets, negative destination stride
        run_xfer("R3", 32'h040, 32'h300, 16'd8, 16'hFFFC, 32'd12, 1'b1, 15'd1, 0, 0);
        // R4: source-only offset, negative
        run_xfer("R4", 32'h100, 32'h180, 16'd4, 16'd4, {1'b1, 1'b0, 20'hFFFC0, 10'd8}, 1'b1, 15'd5, 1, 0);
        // R7: destination-only offset, positive
        run_xfer("R7", 32'h000, 32'h380, 16'd4, 16'd4, {1'b0, 1'b1, 20'h00020, 10'd12}, 1'b1, 15'd2, 0, 0);
        // R4 both sides, negative offset
        run_xfer("R4", 32'h200, 32'h100, 16'd4, 16'd8, {1'b1, 1'b1, 20'hFFFF0, 10'd16}, 1'b1, 15'd1, 0, 0);
        // R5: count not a multiple of four
        run_xfer("R5", 32'h020, 32'h060, 16'd4, 16'd4, 32'd6, 1'b0, 15'd7, 0, 0);
        // R12: zero count, source offset still applied
        run_xfer("R12", 32'h100, 32'h200, 16'd4, 16'd4, {1'b1, 1'b0, 20'h00008, 10'd0}, 1'b1, 15'd4, 0, 0);
        // R9: stall between pairs, then during a read
        run_xfer("R9", 32'h080, 32'h280, 16'd4, 16'd4, 32'd16, 1'b0, 15'd2, 1, 1);
        run_xfer("R9", 32'h0C0, 32'h2C0, 16'd4, 16'd4, 32'd16, 1'b0, 15'd9, 2, 2);
        // R13: stall right at the final grant
        run_xfer("R13", 32'h010, 32'h310, 16'd4, 16'd4, 32'd8, 1'b0, 15'd1, 0, 3);
        // R1: restart attempt while busy is ignored
        run_xfer("R1", 32'h140, 32'h240, 16'd4, 16'd4, 32'd16, 1'b0, 15'd6, 2, 4);

        chk(hold_err == 0, "R8", "request changed before grant", 32'(hold_err), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule